// File: doc/BRIEF.md
# GPIO Controller with Per-Pin Edge Capture

This block is a general-purpose I/O controller for up to 28 pins, reached through a simple word-indexed register bus. Each pin has a direction bit, and each pin can be handed over to a peripheral instead of the GPIO output logic. Software never needs a read-modify-write to change an output level, because setting and clearing go through two separate write-one registers.

Every input is brought into the clock domain through a synchronizer of at least two flops. Each pin has its own rising and falling detectors, and the two are armed separately. A detected event lands in a sticky status register, which software clears by writing ones. A single interrupt line is high while any status bit is set. If a clear and a new event reach the same bit in the same cycle, the event is kept.

Top module: `gpio_edge_ctrl`

## Requirements
- R1: After reset all programmable registers, the output latch and the event status are zero, so `pin_oe` is 0, `pin_out` is 0 and `irq` is 0.
- R2: Reading word index 0 returns the pin inputs after the synchronizer. With two stages, a change on `pin_in` that is driven between edges is readable after the second rising clock edge and not after the first. Writes to index 0 change nothing.
- R3: Index 1 holds the direction, where 1 means output. For a pin whose alternate bit is 0, `pin_oe` equals its direction bit. The value written reads back.
- R4: Writing ones to index 2 drives those output latch bits high, and zero bits are left alone. Index 2 reads as 0.
- R5: Writing ones to index 3 drives those output latch bits low, and zero bits are left alone. Index 3 reads as 0.
- R6: Index 4 arms rising-edge capture per pin. An armed 0 to 1 input change sets the pin's status bit at the third rising clock edge after the change.
- R7: Index 5 arms falling-edge capture per pin, independently of index 4. A pin armed in both registers captures both directions, and an unarmed change is ignored.
- R8: Index 6 reads the event status. Its bits stay set until a 1 is written to them, and writing 0 bits has no effect.
- R9: When a write of 1 to index 6 and a new armed event hit the same bit in the same cycle, the bit stays set.
- R10: Index 7 selects the alternate function. For a pin with its bit at 1, `pin_out` and `pin_oe` follow `periph_out` and `periph_oe`.
- R11: `irq` is high exactly while at least one status bit is set, with no added delay when `IRQ_REG` is 0.
- R12: Register bits at or above `NPINS` read as 0, and writes to those bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when 1, together with `bus_en` |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data for `bus_addr`, combinational |
| pin_in | input | NPINS | Asynchronous pad inputs |
| pin_out | output | NPINS | Pad output levels |
| pin_oe | output | NPINS | Pad output enables |
| periph_out | input | NPINS | Output levels from the alternate peripheral |
| periph_oe | input | NPINS | Output enables from the alternate peripheral |
| irq | output | 1 | Combined event interrupt |

## Verification
The bench builds the block with `NPINS` = 12, `DW` = 32, `SYNC_STAGES` = 2 and `IRQ_REG` = 0. The narrow pin count means bits 12 to 31 of every register can be written and read, so the zero-fill of unused bits can be checked. Two synchronizer stages make the three-edge capture latency exact and predictable, so a status clear can be lined up with a new event in the same cycle. The combinational interrupt lets the cycle-by-cycle model compare `irq` in the same cycle as the status register.

// File: rtl/gpio_edge_pkg.sv
`timescale 1ns/1ps
package gpio_edge_pkg;
   localparam int unsigned REG_ADDR_W = 3;

   // register word indices; software relies on this layout
   typedef enum logic [REG_ADDR_W-1:0] {
      REG_LEVEL = 3'd0,
      REG_DIR   = 3'd1,
      REG_SET   = 3'd2,
      REG_CLR   = 3'd3,
      REG_RISE  = 3'd4,
      REG_FALL  = 3'd5,
      REG_EVT   = 3'd6,
      REG_ALT   = 3'd7
   } gpio_reg_e;
endpackage

// File: rtl/gpio_sync.sv
`timescale 1ns/1ps
module gpio_sync #(
   parameter int unsigned W      = 28,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] din,
   output logic [W-1:0] dout
);
   initial assert (STAGES >= 2) else $error("gpio_sync: STAGES must be at least 2");

   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= din;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign dout = chain[STAGES-1];
endmodule

// File: rtl/gpio_evt.sv
`timescale 1ns/1ps
module gpio_evt #(
   parameter int unsigned W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sync_i,
   input  logic         rise_we,
   input  logic         fall_we,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] rise_en_o,
   output logic [W-1:0] fall_en_o,
   output logic [W-1:0] sts_o,
   output logic         hit_any_o
);
   logic [W-1:0] prev_q, rise_q, fall_q, sts_q;
   logic [W-1:0] hit_w, keep_w;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= '0;
         rise_q <= '0;
         fall_q <= '0;
      end else begin
         prev_q <= sync_i;
         if (rise_we) rise_q <= wdata;
         if (fall_we) fall_q <= wdata;
      end
   end

   // the two directions are armed separately
   assign hit_w  = (sync_i & ~prev_q & rise_q) | (~sync_i & prev_q & fall_q);
   assign keep_w = sts_q & ~clr_i;

   // a fresh event outranks a clear in the same cycle
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sts_q <= '0;
      else        sts_q <= keep_w | hit_w;
   end

   assign rise_en_o = rise_q;
   assign fall_en_o = fall_q;
   assign sts_o     = sts_q;
   assign hit_any_o = |hit_w;

   p_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (|keep_w) |=> ((sts_q & $past(keep_w)) == $past(keep_w)));

   p_event_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hit_w & clr_i)) |=> ((sts_q & $past(hit_w & clr_i)) == $past(hit_w & clr_i)));
endmodule

// File: rtl/gpio_pinmux.sv
`timescale 1ns/1ps
module gpio_pinmux #(
   parameter int unsigned W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         dir_we,
   input  logic         alt_we,
   input  logic         set_stb,
   input  logic         clr_stb,
   input  logic [W-1:0] wdata,
   input  logic [W-1:0] periph_out,
   input  logic [W-1:0] periph_oe,
   output logic [W-1:0] dir_o,
   output logic [W-1:0] alt_o,
   output logic [W-1:0] pin_out,
   output logic [W-1:0] pin_oe
);
   logic [W-1:0] out_q, dir_q, alt_q;
   logic [W-1:0] set_m, clr_m;

   assign set_m = set_stb ? wdata : '0;
   assign clr_m = clr_stb ? wdata : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_q <= '0;
         dir_q <= '0;
         alt_q <= '0;
      end else begin
         out_q <= (out_q | set_m) & ~clr_m;
         if (dir_we) dir_q <= wdata;
         if (alt_we) alt_q <= wdata;
      end
   end

   for (genvar p = 0; p < W; p++) begin : g_pin
      assign pin_out[p] = alt_q[p] ? periph_out[p] : out_q[p];
      assign pin_oe[p]  = alt_q[p] ? periph_oe[p]  : dir_q[p];
   end

   assign dir_o = dir_q;
   assign alt_o = alt_q;

   p_dir_wr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      dir_we |=> (dir_q == $past(wdata)));

   p_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
      set_stb |=> ((out_q & $past(wdata)) == $past(wdata)));

   p_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
      clr_stb |=> ((out_q & $past(wdata)) == '0));
endmodule

// File: rtl/gpio_edge_ctrl.sv
`timescale 1ns/1ps
module gpio_edge_ctrl
   import gpio_edge_pkg::*;
#(
   parameter int unsigned NPINS       = 28,
   parameter int unsigned DW          = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          IRQ_REG     = 1'b0
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  bus_en,
   input  logic                  bus_we,
   input  logic [REG_ADDR_W-1:0] bus_addr,
   input  logic [DW-1:0]         bus_wdata,
   output logic [DW-1:0]         bus_rdata,
   input  logic [NPINS-1:0]      pin_in,
   output logic [NPINS-1:0]      pin_out,
   output logic [NPINS-1:0]      pin_oe,
   input  logic [NPINS-1:0]      periph_out,
   input  logic [NPINS-1:0]      periph_oe,
   output logic                  irq
);
   initial assert (NPINS >= 1 && NPINS <= DW)
      else $error("gpio_edge_ctrl: NPINS must lie in 1..DW");

   logic              wr;
   logic [NPINS-1:0]  wpin, sync_w, dir_w, alt_w, rise_w, fall_w, sts_w, clr_w;
   logic [NPINS-1:0]  rd_pin;
   logic              hit_any;
   logic              unused_wd;
   gpio_reg_e         idx;

   assign idx       = gpio_reg_e'(bus_addr);
   assign wr        = bus_en & bus_we;
   assign wpin      = bus_wdata[NPINS-1:0];
   assign unused_wd = ^bus_wdata;
   assign clr_w     = (wr && idx == REG_EVT) ? wpin : '0;

   gpio_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk (clk), .rst_n (rst_n), .din (pin_in), .dout (sync_w)
   );

   gpio_evt #(.W(NPINS)) u_evt (
      .clk       (clk),
      .rst_n     (rst_n),
      .sync_i    (sync_w),
      .rise_we   (wr && idx == REG_RISE),
      .fall_we   (wr && idx == REG_FALL),
      .wdata     (wpin),
      .clr_i     (clr_w),
      .rise_en_o (rise_w),
      .fall_en_o (fall_w),
      .sts_o     (sts_w),
      .hit_any_o (hit_any)
   );

   gpio_pinmux #(.W(NPINS)) u_mux (
      .clk        (clk),
      .rst_n      (rst_n),
      .dir_we     (wr && idx == REG_DIR),
      .alt_we     (wr && idx == REG_ALT),
      .set_stb    (wr && idx == REG_SET),
      .clr_stb    (wr && idx == REG_CLR),
      .wdata      (wpin),
      .periph_out (periph_out),
      .periph_oe  (periph_oe),
      .dir_o      (dir_w),
      .alt_o      (alt_w),
      .pin_out    (pin_out),
      .pin_oe     (pin_oe)
   );

   always_comb begin
      unique case (idx)
         REG_LEVEL: rd_pin = sync_w;
         REG_DIR:   rd_pin = dir_w;
         REG_RISE:  rd_pin = rise_w;
         REG_FALL:  rd_pin = fall_w;
         REG_EVT:   rd_pin = sts_w;
         REG_ALT:   rd_pin = alt_w;
         default:   rd_pin = '0;
      endcase
      bus_rdata              = '0;
      bus_rdata[NPINS-1:0]   = rd_pin;
   end

   if (IRQ_REG) begin : g_irq_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= |sts_w;
      end
      assign irq = irq_q;
      p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq) |-> $past(hit_any, 2));
   end else begin : g_irq_comb
      assign irq = |sts_w;
      p_irq_rise_r11: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(irq) |-> $past(hit_any));
   end
endmodule

// File: tb/tb_gpio_edge_ctrl.sv
`timescale 1ns/1ps
module tb_gpio_edge_ctrl;
   localparam int N  = 12;
   localparam int DW = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          bus_en = 1'b0, bus_we = 1'b0;
   logic [2:0]    bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic [DW-1:0] bus_rdata;
   logic [N-1:0]  pin_in = '0, pin_out, pin_oe, periph_out = '0, periph_oe = '0;
   logic          irq;

   int n_chk = 0, n_bad = 0;
   bit live = 1'b0;

   always #2.5 clk = ~clk;

   gpio_edge_ctrl #(.NPINS(N), .DW(DW), .SYNC_STAGES(2), .IRQ_REG(1'b0)) dut (
      .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_out(pin_out),
      .pin_oe(pin_oe), .periph_out(periph_out), .periph_oe(periph_oe), .irq(irq)
   );

   // behavioural reference: pin history and register images
   logic [N-1:0] m_s1, m_s2, m_prev, m_out, m_dir, m_rise, m_fall, m_sts, m_alt;

   always @(posedge clk) begin
      logic [N-1:0] hit, wd, clr;
      if (!rst_n) begin
         m_s1 = '0; m_s2 = '0; m_prev = '0; m_out = '0; m_dir = '0;
         m_rise = '0; m_fall = '0; m_sts = '0; m_alt = '0;
      end else begin
         wd  = bus_wdata[N-1:0];
         hit = 0;
         for (int p = 0; p < N; p++) begin
            if (m_rise[p] && m_s2[p] && !m_prev[p]) hit[p] = 1'b1;
            if (m_fall[p] && !m_s2[p] && m_prev[p]) hit[p] = 1'b1;
         end
         clr = (bus_en && bus_we && bus_addr == 3'd6) ? wd : '0;
         m_sts  = (m_sts & ~clr) | hit;
         m_prev = m_s2; m_s2 = m_s1; m_s1 = pin_in;
         if (bus_en && bus_we) begin
            case (bus_addr)
               3'd1: m_dir  = wd;
               3'd2: m_out  = m_out | wd;
               3'd3: m_out  = m_out & ~wd;
               3'd4: m_rise = wd;
               3'd5: m_fall = wd;
               3'd7: m_alt  = wd;
               default: ;
            endcase
         end
      end
   end

   function automatic logic [DW-1:0] exp_rd(input logic [2:0] a);
      logic [N-1:0] v;
      case (a)
         3'd0: v = m_s2;
         3'd1: v = m_dir;
         3'd4: v = m_rise;
         3'd5: v = m_fall;
         3'd6: v = m_sts;
         3'd7: v = m_alt;
         default: v = '0;
      endcase
      return {{(DW-N){1'b0}}, v};
   endfunction

   function automatic string tag_of(input logic [2:0] a);
      case (a)
         3'd0: return "R2";  3'd1: return "R3";  3'd2: return "R4";  3'd3: return "R5";
         3'd4: return "R6";  3'd5: return "R7";  3'd6: return "R8";  default: return "R10";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      #1;
      if (rst_n && live) begin
         chk("R4 pin_out", DW'(pin_out), DW'((m_alt & periph_out) | (~m_alt & m_out)));
         chk("R3 pin_oe",  DW'(pin_oe),  DW'((m_alt & periph_oe)  | (~m_alt & m_dir)));
         chk("R11 irq",    DW'(irq),     DW'(|m_sts));
         chk({tag_of(bus_addr), " rdata"}, bus_rdata, exp_rd(bus_addr));
      end
   end

   task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
      @(negedge clk);
      bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_en = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
      @(negedge clk);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      finish_run();
   end

   initial begin
      logic [DW-1:0] v;
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1; live = 1'b1;

      // R1: reset state
      for (int a = 0; a < 8; a++) begin
         rd(3'(a), v); chk("R1 reg after reset", v, '0);
      end
      chk("R1 pin_oe", DW'(pin_oe), '0);
      chk("R1 pin_out", DW'(pin_out), '0);
      chk("R1 irq", DW'(irq), '0);

      // R3 direction, R12 upper bits
      wr(3'd1, 32'hFFFF_FF0F);
      rd(3'd1, v); chk("R12 dir upper bits", v, 32'h0000_0F0F);
      chk("R3 pin_oe", DW'(pin_oe), 32'h0F0F);

      // R4 / R5 set and clear
      wr(3'd2, 32'h0000_000F);
      chk("R4 set", DW'(pin_out), 32'h000F);
      rd(3'd2, v); chk("R4 set reads zero", v, '0);
      wr(3'd3, 32'h0000_0005);
      chk("R5 clear", DW'(pin_out), 32'h000A);
      rd(3'd3, v); chk("R5 clear reads zero", v, '0);

      // R2 level write ignored, sync latency
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v); chk("R2 level write ignored", v, '0);
      @(negedge clk); pin_in = 12'h0A5;
      @(posedge clk);
      rd(3'd0, v); chk("R2 level after one edge", v, '0);
      rd(3'd0, v); chk("R2 level after two edges", v, 32'h0A5);

      // R6 / R7 arm: pin0 rise, pin1 fall, pin2 both
      @(negedge clk); pin_in = '0;
      repeat (4) @(posedge clk);
      wr(3'd4, 32'h5);
      wr(3'd5, 32'h6);
      @(negedge clk); pin_in = 12'h007;
      repeat (3) @(posedge clk);
      rd(3'd6, v); chk("R6 rising capture", v, 32'h5);
      chk("R11 irq set", DW'(irq), 32'h1);
      @(negedge clk); pin_in = '0;
      repeat (3) @(posedge clk);
      rd(3'd6, v); chk("R7 falling capture", v, 32'h7);

      // R8 write-one clear, zero bits no effect
      wr(3'd6, 32'h0);
      rd(3'd6, v); chk("R8 zero write keeps", v, 32'h7);
      wr(3'd6, 32'h1);
      rd(3'd6, v); chk("R8 one clears", v, 32'h6);
      wr(3'd6, 32'hFFFF_FFFF);
      rd(3'd6, v); chk("R8 all cleared", v, '0);
      chk("R11 irq low", DW'(irq), '0);

      // R9 clear and new event in the same cycle
      @(negedge clk); pin_in = 12'h004;
      @(negedge clk);
      @(negedge clk); bus_en = 1'b1; bus_we = 1'b1; bus_addr = 3'd6; bus_wdata = 32'h4;
      @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
      rd(3'd6, v); chk("R9 event beats clear", v, 32'h4);
      wr(3'd6, 32'h4);

      // R10 alternate function
      @(negedge clk); periph_out = 12'h001; periph_oe = 12'h003;
      wr(3'd7, 32'h3);
      chk("R10 alt pin_out", DW'(pin_out[1:0]), 32'h1);
      chk("R10 alt pin_oe", DW'(pin_oe[1:0]), 32'h3);
      chk("R10 gpio pin untouched", DW'(pin_out[3]), 32'h1);

      // mixed traffic under the model
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         pin_in     = N'($urandom);
         periph_out = N'($urandom);
         periph_oe  = N'($urandom);
         bus_addr   = 3'($urandom);
         bus_wdata  = $urandom;
         bus_en     = ($urandom % 4) == 0;
         bus_we     = $urandom % 2;
      end
      @(negedge clk); bus_en = 1'b0; bus_we = 1'b0;
      repeat (4) @(negedge clk);
      finish_run();
   end
endmodule